// File: doc/BRIEF.md
# Interval Timer Counter Channel

One channel of a programmable interval timer: a down-counter of `CNT_W` bits, 16 by default, that moves only on cycles where the count-enable strobe `tick_i` is high. That strobe is nominally a one-cycle pulse at 1193182 Hz. The channel holds three values. The first is the value most recently written through `load_i`/`load_val_i`. The second is the value in force for the current run. The third is the live count, which appears on `count_o` so a host-side latch can capture it. `out_o` is the channel's waveform output, and its shape depends on `mode_i`.

Six waveforms are supported:

- mode 0: level on terminal count
- mode 1: retriggerable one-shot
- mode 2: rate generator
- mode 3: square wave
- mode 4: strobe started by software
- mode 5: strobe started by the gate

Modes 0 and 4 start from a count write. Modes 1, 2, 3 and 5 start, or restart, on a rising edge of `gate_i`. A written value of zero means a full span of 2^`CNT_W` ticks.

`mode_i` is treated as static configuration and is changed only while reset is held. The `GATE_RST` parameter gives the gate level assumed at reset, so that a channel whose gate idles low (a tone channel) sees no false edge.

Top module: `interval_count_channel`

## Requirements
- R1: After reset `out_o` is 1 and `count_o` is 0, meaning a full 65536-tick span. With `mode_i`=3 and the gate high, the first tick gives `count_o`=16'hFFFE and `out_o`=1.
- R2: `count_o` changes only in cycles where `tick_i` is 1. A written value of 0 counts as 65536 ticks: the applying tick shows 0, and the next tick shows 16'hFFFF with `out_o` still 0 in mode 0.
- R3: Mode 0:
  - A write drives `out_o` to 0 in the next cycle.
  - The next tick loads the value N and counts as tick index e=0.
  - After tick index e, `count_o` is N-e and `out_o` is 1 exactly when e >= N.
  - `out_o` then stays 1 until the next write.
- R4: In modes 0 and 4 a written value takes effect on the first tick after the write, whatever the gate level. After that, a tick with `gate_i` low leaves the count unchanged.
- R5: Mode 1:
  - A tick with no gate edge pending leaves `out_o` at 1.
  - The tick that consumes a gate rising edge is e=0: it loads N and drives `out_o` to 0.
  - After tick index e, `count_o` is N-e, and `out_o` returns to 1 once e >= N.
- R6: Mode 2 with value N, counting from the triggering tick e=0:
  - `count_o` is N-(e mod N).
  - `out_o` is 0 exactly when e mod N = N-1.
- R7: Mode 3 with value N, counting from the triggering tick:
  - `out_o` is 1 when e mod N < (N+1)/2, and 0 otherwise.
  - Inside a half period the count falls by 2 on each tick.
  - For even N, `count_o` is N-2·(e mod (N/2)).
- R8: Modes 4 and 5 pulse `out_o` low for exactly one tick, at e=N, and then keep it at 1. A write in mode 4 holds `out_o` at 1. In mode 5 a write with no gate edge produces no pulse.
- R9: In modes 1, 2, 3 and 5, a rising edge on `gate_i` restarts the run from the written value at the next tick. An edge that arrives between ticks is held until that tick.
- R10: `mode_i` values 6 and 7 give exactly the behaviour of modes 2 and 3.
- R11: In modes 2 and 3, a value written mid-period is used only when the current period ends.
- R12: In modes 0, 1, 4 and 5 the count wraps past 0 to 16'hFFFF and keeps falling, and `out_o` does not change.
- R13: In modes 2 and 3, a tick with `gate_i` low holds the count and forces `out_o` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable strobe, one cycle per timer input tick |
| mode_i | input | 3 | Waveform mode 0..7 (6 and 7 fold to 2 and 3) |
| gate_i | input | 1 | Gate: a level in modes 0/4, and a rising edge triggers in modes 1/2/3/5 |
| load_i | input | 1 | One-cycle strobe to write `load_val_i` |
| load_val_i | input | CNT_W | Count value (0 means 2^CNT_W) |
| out_o | output | 1 | Channel waveform output |
| count_o | output | CNT_W | Live count for latching by a host interface |

## Verification
The bench targets several corner cases. Each has a characteristic failure:

- **Wrap past zero.** A design that stops at zero, or lets the wrap re-fire the output, would show a stuck count or a second strobe pulse.
- **Gate edges between ticks.** If such an edge were lost, modes 1, 2, 3 and 5 would never start.
- **Deferred reload.** Writing mid-period in the rate generator checks that the new value waits for the period boundary. A design that reloads at once would shorten the running period.
- **Odd square-wave counts.** These expose a wrong split of the high and low halves.
- **Mode aliases.** These catch a decoder that treats 6 and 7 as undefined.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [2:0] {
    MODE_TERM     = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } mode_e;

  // Encodings 6 and 7 drop their top bit and become 2 and 3.
  function automatic mode_e fold_mode(input logic [2:0] m);
    if (m[2] && m[1]) return mode_e'({1'b0, m[1:0]});
    return mode_e'(m);
  endfunction

endpackage

// File: rtl/icc_gate_edge.sv
module icc_gate_edge #(
  parameter bit GATE_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  input  logic tick_i,
  output logic trig_o
);
  logic gate_q;
  logic held_q;
  logic rise_w;

  assign rise_w = gate_i & ~gate_q;
  assign trig_o = rise_w | held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= GATE_RST;
      held_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (tick_i)      held_q <= 1'b0;
      else if (rise_w) held_q <= 1'b1;
    end
  end

  // R9
  edge_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_w && !tick_i) |=> trig_o);

endmodule

// File: rtl/icc_core.sv
module icc_core
  import icc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  mode_e            mode_i,
  input  logic             gate_i,
  input  logic             trig_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             out_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_n, act_q, act_n, rel_q, rel_n;
  logic out_q, out_n, armed_q, armed_n, pend_q, pend_n;

  logic exhaust_w;
  logic rate_end_w;
  logic half_end_w;

  assign exhaust_w  = (cnt_q == ONE);
  assign rate_end_w = (cnt_q == ONE);
  assign half_end_w = (cnt_q == TWO);

  // Start value of a square-wave half: an odd count rounds the high half up
  // and the low half down.
  function automatic logic [CNT_W-1:0] half_init(input logic [CNT_W-1:0] n,
                                                 input logic hi);
    return hi ? n + CNT_W'(n[0]) : n - CNT_W'(n[0]);
  endfunction

  always_comb begin
    cnt_n   = cnt_q;
    act_n   = act_q;
    rel_n   = rel_q;
    out_n   = out_q;
    armed_n = armed_q;
    pend_n  = pend_q;

    if (tick_i) begin
      case (mode_i)
        MODE_TERM, MODE_SWSTROBE: begin
          if (mode_i == MODE_SWSTROBE && !out_q) out_n = 1'b1;
          if (pend_q) begin
            cnt_n   = rel_q;
            act_n   = rel_q;
            armed_n = 1'b1;
            pend_n  = 1'b0;
          end else if (gate_i) begin
            cnt_n = cnt_q - ONE;
            if (exhaust_w && armed_q) begin
              out_n   = (mode_i == MODE_TERM);
              armed_n = 1'b0;
            end
          end
        end
        MODE_ONESHOT, MODE_HWSTROBE: begin
          if (mode_i == MODE_HWSTROBE && !out_q) out_n = 1'b1;
          if (trig_i) begin
            cnt_n   = rel_q;
            act_n   = rel_q;
            armed_n = 1'b1;
            out_n   = (mode_i == MODE_HWSTROBE);
          end else begin
            cnt_n = cnt_q - ONE;
            if (exhaust_w && armed_q) begin
              out_n   = (mode_i == MODE_ONESHOT);
              armed_n = 1'b0;
            end
          end
        end
        MODE_RATE: begin
          if (trig_i) begin
            cnt_n = rel_q;
            act_n = rel_q;
            out_n = 1'b1;
          end else if (!gate_i) begin
            out_n = 1'b1;
          end else if (rate_end_w) begin
            cnt_n = rel_q;
            act_n = rel_q;
            out_n = 1'b1;
          end else begin
            cnt_n = cnt_q - ONE;
            if (half_end_w) out_n = 1'b0;
          end
        end
        MODE_SQUARE: begin
          if (trig_i) begin
            act_n = rel_q;
            cnt_n = half_init(rel_q, 1'b1);
            out_n = 1'b1;
          end else if (!gate_i) begin
            out_n = 1'b1;
          end else if (half_end_w) begin
            if (out_q) begin
              out_n = 1'b0;
              cnt_n = half_init(act_q, 1'b0);
            end else begin
              out_n = 1'b1;
              act_n = rel_q;
              cnt_n = half_init(rel_q, 1'b1);
            end
          end else begin
            cnt_n = cnt_q - TWO;
          end
        end
        default: ;
      endcase
    end

    if (load_i) begin
      rel_n  = load_val_i;
      pend_n = 1'b1;
      if (mode_i == MODE_TERM)     out_n = 1'b0;
      if (mode_i == MODE_SWSTROBE) out_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= '0;
      rel_q   <= '0;
      out_q   <= 1'b1;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      act_q   <= act_n;
      rel_q   <= rel_n;
      out_q   <= out_n;
      armed_q <= armed_n;
      pend_q  <= pend_n;
    end
  end

  assign out_o = out_q;
  assign cnt_o = cnt_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));

  // R3
  term_load_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && mode_i == MODE_TERM) |=> !out_q);

  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == MODE_SWSTROBE || mode_i == MODE_HWSTROBE) && tick_i && !out_q)
    |=> out_q);

  // R7
  sq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_SQUARE && tick_i && gate_i && !trig_i && !half_end_w)
    |=> cnt_q == $past(cnt_q) - TWO);

  // R6
  rate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_RATE && tick_i && gate_i && !trig_i && half_end_w)
    |=> (!out_q && cnt_q == ONE));

  // R5
  oneshot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_ONESHOT && tick_i && trig_i && !load_i)
    |=> (!out_q && cnt_q == $past(rel_q)));

endmodule

// File: rtl/interval_count_channel.sv
module interval_count_channel
  import icc_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit GATE_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [2:0]       mode_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  mode_e mode_w;
  logic  trig_w;

  assign mode_w = fold_mode(mode_i);

  icc_gate_edge #(.GATE_RST(GATE_RST)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate_i),
    .tick_i (tick_i),
    .trig_o (trig_w)
  );

  icc_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .mode_i     (mode_w),
    .gate_i     (gate_i),
    .trig_i     (trig_w),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .out_o      (out_o),
    .cnt_o      (count_o)
  );

  // R10
  alias_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[2] && mode_i[1]) |-> (mode_w[2] == 1'b0 && mode_w[1:0] == mode_i[1:0]));

endmodule

// File: tb/interval_count_channel_tb.sv
`timescale 1ns/1ps
module interval_count_channel_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, gate = 1'b1, load = 1'b0;
  logic [2:0]  mode = 3'd3;
  logic [15:0] lval = '0;
  logic        out;
  logic [15:0] cnt;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  bit          q_out[$];
  logic [15:0] q_cnt[$];
  bit          q_chk[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  interval_count_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(mode), .gate_i(gate),
    .load_i(load), .load_val_i(lval), .out_o(out), .count_o(cnt)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [2:0] m, input logic g);
    @(negedge clk);
    rst_n = 1'b0; mode = m; gate = g; tick = 1'b0; load = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_count(input logic [15:0] v);
    @(negedge clk); load = 1'b1; lval = v;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk); gate = g;
  endtask

  // Driver: push the expectation, then issue one tick.
  task automatic step(input bit eo, input logic [15:0] ec, input bit cc, input string tag);
    q_out.push_back(eo); q_cnt.push_back(ec); q_chk.push_back(cc); q_tag.push_back(tag);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // Monitor: after every tick edge, compare with the oldest expectation.
  initial begin
    forever begin
      @(posedge clk);
      if (tick === 1'b1) begin
        @(negedge clk);
        if (q_out.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL scoreboard empty actual=%h expected=none", cnt);
        end else begin
          automatic bit          eo = q_out.pop_front();
          automatic logic [15:0] ec = q_cnt.pop_front();
          automatic bit          cc = q_chk.pop_front();
          automatic string       tg = q_tag.pop_front();
          check({tg, " out"}, {15'd0, out}, {15'd0, eo});
          if (cc) check({tg, " count"}, cnt, ec);
        end
      end
    end
  end

  function automatic int span(input int n);
    return (n == 0) ? 65536 : n;
  endfunction

  initial begin
    // R1 reset state and default square wave
    restart(3'd3, 1'b1);
    check("R1 reset out", {15'd0, out}, 16'd1);
    check("R1 reset count", cnt, 16'd0);
    step(1'b1, 16'hFFFE, 1'b1, "R1 R7 default square");

    // R3 R4 R12 mode 0
    restart(3'd0, 1'b1);
    write_count(16'd6);
    check("R3 out low after write", {15'd0, out}, 16'd0);
    for (int e = 0; e < 3; e++) step(1'b0, 16'(6 - e), 1'b1, "R3 mode0");
    repeat (3) @(negedge clk);
    check("R2 no tick hold", cnt, 16'd4);
    set_gate(1'b0);
    for (int k = 0; k < 3; k++) step(1'b0, 16'd4, 1'b1, "R4 gate pause");
    set_gate(1'b1);
    for (int e = 3; e < 8; e++) step(e >= 6, 16'(6 - e), 1'b1, "R3 R12 mode0");
    write_count(16'd2);
    check("R3 reload low", {15'd0, out}, 16'd0);
    for (int e = 0; e < 3; e++) step(e >= 2, 16'(2 - e), 1'b1, "R4 next tick load");

    // R2 zero means full span
    restart(3'd0, 1'b1);
    write_count(16'd0);
    step(1'b0, 16'd0, 1'b1, "R2 zero applied");
    step(1'b0, 16'hFFFF, 1'b1, "R2 zero span");

    // R5 R9 R12 mode 1
    restart(3'd1, 1'b0);
    write_count(16'd3);
    step(1'b1, 16'd0, 1'b0, "R5 no trigger");
    set_gate(1'b1);
    for (int e = 0; e < 5; e++) step(e >= 3, 16'(3 - e), 1'b1, "R5 R12 oneshot");
    set_gate(1'b0);
    set_gate(1'b1);
    step(1'b0, 16'd3, 1'b1, "R9 oneshot retrigger");
    step(1'b0, 16'd2, 1'b1, "R9 oneshot retrigger");

    // R6 R11 R13 mode 2
    restart(3'd2, 1'b0);
    write_count(16'd4);
    set_gate(1'b1);
    for (int e = 0; e < 6; e++) step((e % 4) != 3, 16'(4 - (e % 4)), 1'b1, "R6 rate");
    write_count(16'd6);
    step(1'b1, 16'd2, 1'b1, "R11 old period");
    step(1'b0, 16'd1, 1'b1, "R11 old period");
    step(1'b1, 16'd6, 1'b1, "R11 new period");
    step(1'b1, 16'd5, 1'b1, "R11 new period");
    set_gate(1'b0);
    step(1'b1, 16'd5, 1'b1, "R13 rate paused");

    // R10 mode 6 acts as mode 2
    restart(3'd6, 1'b0);
    write_count(16'd3);
    set_gate(1'b1);
    for (int e = 0; e < 7; e++) step((e % 3) != 2, 16'(3 - (e % 3)), 1'b1, "R10 mode6");

    // R7 odd square
    restart(3'd3, 1'b0);
    write_count(16'd5);
    set_gate(1'b1);
    for (int e = 0; e < 10; e++) step((e % 5) < 3, 16'd0, 1'b0, "R7 odd square");

    // R10 R7 R13 mode 7 acts as mode 3
    restart(3'd7, 1'b0);
    write_count(16'd4);
    set_gate(1'b1);
    for (int e = 0; e < 7; e++) step((e % 4) < 2, 16'(4 - 2 * (e % 2)), 1'b1, "R10 R7 mode7");
    set_gate(1'b0);
    step(1'b1, 16'd4, 1'b1, "R13 square paused");

    // R8 mode 4
    restart(3'd4, 1'b1);
    write_count(16'd3);
    check("R8 mode4 write high", {15'd0, out}, 16'd1);
    for (int e = 0; e < 6; e++) step(e != 3, 16'(3 - e), 1'b1, "R8 R12 mode4");

    // R8 R9 mode 5
    restart(3'd5, 1'b0);
    write_count(16'd2);
    step(1'b1, 16'd0, 1'b0, "R8 mode5 no trigger");
    step(1'b1, 16'd0, 1'b0, "R8 mode5 no trigger");
    set_gate(1'b1);
    for (int e = 0; e < 5; e++) step(e != 2, 16'(2 - e), 1'b1, "R8 R12 mode5");
    set_gate(1'b0);
    set_gate(1'b1);
    step(1'b1, 16'd2, 1'b1, "R9 mode5 retrigger");

    repeat (3) @(negedge clk);
    if (span(0) != 65536) check("R2 span helper", 16'd0, 16'd1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule